// File: doc/BRIEF.md
# Pixel-Doubled Scan Address Generator

This block turns the horizontal and vertical coordinates of a 640x480 display scan into fetch addresses for two frame stores, then merges what comes back into one colour. A half-resolution 320x240 image of 16-bit pixels is shown at full screen size by repeating each stored pixel across a 2x2 block of screen pixels. An 80x60 text layer of 8x8 character cells sits on top of the image. The block gives the character-store address and the row and column inside the glyph, so that a font lookup outside the block can return one font bit.

Both addresses are formed by placing coordinate fields at fixed bit positions, with no multiplier. In the image store one row of pixels spans 1024 bytes and one pixel spans 2 bytes. In the character store one row of cells spans 128 bytes and one cell spans 1 byte. The base address of the image store is held in a register that can be rewritten at run time. The base address of the character store is a parameter.

When the font bit is set, the output pixel is white. Otherwise the output shows the fetched image colour. Outside the visible area the output is black.

Top module: `pixdbl_scan_addr`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero at that edge and the image base register returns to `PIX_BASE_RST` (default 0).
- R2: One clock edge after the coordinates (sx, sy) are sampled, `pix_addr` equals base + ((sy>>1)<<10) + ((sx>>1)<<1).
- R3: The four screen pixels (2i,2j), (2i+1,2j), (2i,2j+1) and (2i+1,2j+1) all produce the same `pix_addr`.
- R4: A write on `base_wr`/`base_din` at clock edge k updates the image base. The address registered at edge k still uses the old base. Addresses registered from edge k+1 onward use the new base.
- R5: One clock edge after the coordinates are sampled, `chr_addr` equals `CHR_BASE` + ((sy>>3)<<7) + (sx>>3). Screen (632,472) gives offset 0x1DCF.
- R6: `glyph_col` equals sx[2:0] and `glyph_row` equals sy[2:0]. Both are registered on the same edge as the addresses.
- R7: When `font_bit` is 0, the colour output one edge after the addresses shows the returned halfword: `red` = bits 15:11, `green` = bits 10:5, `blue` = bits 4:0.
- R8: When `font_bit` is 1, the colour output is white: red 0x1F, green 0x3F, blue 0x1F.
- R9: When sx >= 640 or sy >= 480, the colour output two edges later is zero, whatever the font bit and the returned data. (639,479) is still visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr | input | 1 | Write strobe for the image base register |
| base_din | input | 32 | New image base address |
| scr_x | input | 10 | Screen column of the current scan position |
| scr_y | input | 10 | Screen line of the current scan position |
| pix_addr | output | 32 | Byte address of the image pixel to fetch |
| chr_addr | output | 32 | Byte address of the character code to fetch |
| glyph_col | output | 3 | Column inside the 8x8 glyph |
| glyph_row | output | 3 | Row inside the 8x8 glyph |
| pix_data | input | 16 | Returned image pixel (5-6-5 colour) |
| font_bit | input | 1 | Returned font bit for the current glyph position |
| red | output | 5 | Red component |
| green | output | 6 | Green component |
| blue | output | 5 | Blue component |

## Verification
The bench probes the far corners of both stores, (638,478) and (632,472), so that a field placed one bit off shows up as a wrong offset. Each 2x2 block and each odd coordinate is checked, which catches a design that drops the halving and would step the address on every screen pixel. A base write is checked on the edge it lands and on the edge after it, so a design that applies the new base one cycle early or one cycle late is caught. Coordinates just past the visible edge are driven with white font bits set, which exposes a blanking compare that is off by one or that lets the overlay win over blanking.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  typedef struct packed {
    logic [4:0] r;
    logic [5:0] g;
    logic [4:0] b;
  } rgb565_t;

  localparam rgb565_t RGB_WHITE = '{r: 5'h1F, g: 6'h3F, b: 5'h1F};
  localparam rgb565_t RGB_BLACK = '{r: 5'h00, g: 6'h00, b: 5'h00};

  function automatic rgb565_t split565(input logic [15:0] hw);
    rgb565_t c;
    c.r = hw[15:11];
    c.g = hw[10:5];
    c.b = hw[4:0];
    return c;
  endfunction
endpackage

// File: rtl/pdb_pix_addr.sv
module pdb_pix_addr #(
  parameter int          CRD_W        = 10,
  parameter int          ADDR_W       = 32,
  parameter logic [31:0] PIX_BASE_RST = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_din,
  input  logic [CRD_W-1:0]  sx,
  input  logic [CRD_W-1:0]  sy,
  output logic [ADDR_W-1:0] addr_q
);
  // image pixel = screen >> 1; row stride = 2^CRD_W bytes, pixel = 2 bytes
  localparam int IMG_W  = CRD_W - 1;
  localparam int ROW_SH = CRD_W;

  logic [ADDR_W-1:0] base_q;
  logic [IMG_W-1:0]  ix, iy;
  logic [ADDR_W-1:0] offs;

  assign ix   = sx[CRD_W-1:1];
  assign iy   = sy[CRD_W-1:1];
  assign offs = (ADDR_W'(iy) << ROW_SH) | (ADDR_W'(ix) << 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= ADDR_W'(PIX_BASE_RST);
      addr_q <= '0;
    end else begin
      if (base_wr) base_q <= base_din;
      addr_q <= base_q + offs;
    end
  end
endmodule

// File: rtl/pdb_chr_addr.sv
module pdb_chr_addr #(
  parameter int          CRD_W     = 10,
  parameter int          ADDR_W    = 32,
  parameter int          CELL_LG   = 3,
  parameter int          STRIDE_LG = 7,
  parameter logic [31:0] CHR_BASE  = 32'h0001_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CRD_W-1:0]   sx,
  input  logic [CRD_W-1:0]   sy,
  output logic [ADDR_W-1:0]  addr_q,
  output logic [CELL_LG-1:0] gcol_q,
  output logic [CELL_LG-1:0] grow_q
);
  localparam int CELL_W = CRD_W - CELL_LG;

  logic [CELL_W-1:0] cx, cy;
  logic [ADDR_W-1:0] offs;

  assign cx   = sx[CRD_W-1:CELL_LG];
  assign cy   = sy[CRD_W-1:CELL_LG];
  assign offs = (ADDR_W'(cy) << STRIDE_LG) | ADDR_W'(cx);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      gcol_q <= '0;
      grow_q <= '0;
    end else begin
      addr_q <= ADDR_W'(CHR_BASE) + offs;
      gcol_q <= sx[CELL_LG-1:0];
      grow_q <= sy[CELL_LG-1:0];
    end
  end
endmodule

// File: rtl/pdb_color_mux.sv
module pdb_color_mux
  import pdb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        vis,
  input  logic [15:0] pix_data,
  input  logic        font_bit,
  output rgb565_t     rgb_q
);
  rgb565_t nxt;

  always_comb begin
    if (!vis)         nxt = RGB_BLACK;
    else if (font_bit) nxt = RGB_WHITE;
    else              nxt = split565(pix_data);
  end

  always_ff @(posedge clk) begin
    if (rst) rgb_q <= RGB_BLACK;
    else     rgb_q <= nxt;
  end
endmodule

// File: rtl/pixdbl_scan_addr.sv
module pixdbl_scan_addr
  import pdb_pkg::*;
#(
  parameter int          CRD_W        = 10,
  parameter int          ADDR_W       = 32,
  parameter int          H_ACT        = 640,
  parameter int          V_ACT        = 480,
  parameter int          CELL_LG      = 3,
  parameter int          STRIDE_LG    = 7,
  parameter int          RD_LAT       = 1,
  parameter logic [31:0] PIX_BASE_RST = 32'h0,
  parameter logic [31:0] CHR_BASE     = 32'h0001_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               base_wr,
  input  logic [ADDR_W-1:0]  base_din,
  input  logic [CRD_W-1:0]   scr_x,
  input  logic [CRD_W-1:0]   scr_y,
  output logic [ADDR_W-1:0]  pix_addr,
  output logic [ADDR_W-1:0]  chr_addr,
  output logic [CELL_LG-1:0] glyph_col,
  output logic [CELL_LG-1:0] glyph_row,
  input  logic [15:0]        pix_data,
  input  logic               font_bit,
  output logic [4:0]         red,
  output logic [5:0]         green,
  output logic [4:0]         blue
);
  localparam int VP_LEN = RD_LAT;

  logic            vis_now;
  logic [VP_LEN:0] vis_pipe;
  rgb565_t         rgb;

  assign vis_now     = (scr_x < CRD_W'(H_ACT)) && (scr_y < CRD_W'(V_ACT));
  assign vis_pipe[0] = vis_now;

  // visibility travels alongside the memory read latency
  for (genvar i = 0; i < VP_LEN; i++) begin : g_vis
    always_ff @(posedge clk) begin
      if (rst) vis_pipe[i+1] <= 1'b0;
      else     vis_pipe[i+1] <= vis_pipe[i];
    end
  end

  pdb_pix_addr #(
    .CRD_W(CRD_W), .ADDR_W(ADDR_W), .PIX_BASE_RST(PIX_BASE_RST)
  ) u_pix (
    .clk(clk), .rst(rst), .base_wr(base_wr), .base_din(base_din),
    .sx(scr_x), .sy(scr_y), .addr_q(pix_addr)
  );

  pdb_chr_addr #(
    .CRD_W(CRD_W), .ADDR_W(ADDR_W), .CELL_LG(CELL_LG),
    .STRIDE_LG(STRIDE_LG), .CHR_BASE(CHR_BASE)
  ) u_chr (
    .clk(clk), .rst(rst), .sx(scr_x), .sy(scr_y),
    .addr_q(chr_addr), .gcol_q(glyph_col), .grow_q(glyph_row)
  );

  pdb_color_mux u_col (
    .clk(clk), .rst(rst), .vis(vis_pipe[VP_LEN]),
    .pix_data(pix_data), .font_bit(font_bit), .rgb_q(rgb)
  );

  assign red   = rgb.r;
  assign green = rgb.g;
  assign blue  = rgb.b;
endmodule

// File: rtl/pdb_scan_chk.sv
module pdb_scan_chk #(
  parameter int CRD_W   = 10,
  parameter int ADDR_W  = 32,
  parameter int H_ACT   = 640,
  parameter int V_ACT   = 480,
  parameter int CELL_LG = 3,
  parameter int RD_LAT  = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               base_wr,
  input logic [CRD_W-1:0]   scr_x,
  input logic [CRD_W-1:0]   scr_y,
  input logic [ADDR_W-1:0]  pix_addr,
  input logic [ADDR_W-1:0]  chr_addr,
  input logic [CELL_LG-1:0] glyph_col,
  input logic [CELL_LG-1:0] glyph_row,
  input logic               font_bit,
  input logic [4:0]         red,
  input logic [5:0]         green,
  input logic [4:0]         blue
);
  logic on_screen;
  assign on_screen = (int'(scr_x) < H_ACT) && (int'(scr_y) < V_ACT);

  // R1
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (red == 0 && green == 0 && blue == 0 && pix_addr == 0 &&
             chr_addr == 0 && glyph_col == 0 && glyph_row == 0));

  // R3
  a_r3_pixel_repeat: assert property (@(posedge clk) disable iff (rst)
    ($stable(scr_x[CRD_W-1:1]) && $stable(scr_y[CRD_W-1:1]) &&
     !$past(base_wr) && !$past(rst)) |=> $stable(pix_addr));

  // R5
  a_r5_cell_repeat: assert property (@(posedge clk) disable iff (rst)
    ($stable(scr_x[CRD_W-1:CELL_LG]) && $stable(scr_y[CRD_W-1:CELL_LG]) &&
     !$past(rst)) |=> $stable(chr_addr));

  // R6
  a_r6_glyph_pos: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (glyph_col == $past(scr_x[CELL_LG-1:0]) &&
              glyph_row == $past(scr_y[CELL_LG-1:0])));

  if (RD_LAT == 1) begin : g_lat1
    // R8
    a_r8_font_white: assert property (@(posedge clk) disable iff (rst)
      on_screen ##1 font_bit |=> (red == 5'h1F && green == 6'h3F && blue == 5'h1F));

    // R9
    a_r9_blank: assert property (@(posedge clk) disable iff (rst)
      !on_screen |-> ##2 (red == 0 && green == 0 && blue == 0));
  end
endmodule

bind pixdbl_scan_addr pdb_scan_chk #(
  .CRD_W(CRD_W), .ADDR_W(ADDR_W), .H_ACT(H_ACT), .V_ACT(V_ACT),
  .CELL_LG(CELL_LG), .RD_LAT(RD_LAT)
) u_chk (
  .clk(clk), .rst(rst), .base_wr(base_wr), .scr_x(scr_x), .scr_y(scr_y),
  .pix_addr(pix_addr), .chr_addr(chr_addr), .glyph_col(glyph_col),
  .glyph_row(glyph_row), .font_bit(font_bit), .red(red), .green(green),
  .blue(blue)
);

// File: tb/pixdbl_scan_addr_test.sv
module pixdbl_scan_addr_test;
  localparam logic [31:0] CB = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_wr = 1'b0;
  logic [31:0] base_din = '0;
  logic [9:0]  scr_x = '0, scr_y = '0;
  logic [15:0] pix_data = '0;
  logic        font_bit = 1'b0;
  logic [31:0] pix_addr, chr_addr;
  logic [2:0]  glyph_col, glyph_row;
  logic [4:0]  red, blue;
  logic [5:0]  green;

  int checks = 0;
  int errors = 0;
  logic [31:0] cur_base = '0;

  always #4 clk = ~clk;

  pixdbl_scan_addr uut (
    .clk(clk), .rst(rst), .base_wr(base_wr), .base_din(base_din),
    .scr_x(scr_x), .scr_y(scr_y), .pix_addr(pix_addr), .chr_addr(chr_addr),
    .glyph_col(glyph_col), .glyph_row(glyph_row), .pix_data(pix_data),
    .font_bit(font_bit), .red(red), .green(green), .blue(blue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pix(input logic [31:0] b, input int x, input int y);
    return b + 32'((y / 2) * 1024) + 32'((x / 2) * 2);
  endfunction

  function automatic logic [31:0] exp_chr(input int x, input int y);
    return CB + 32'((y / 8) * 128) + 32'(x / 8);
  endfunction

  function automatic logic [31:0] rgb_word();
    return {16'h0, red, green, blue};
  endfunction

  // all tasks start and end at a falling edge
  task automatic put_xy(input int x, input int y);
    scr_x = 10'(x);
    scr_y = 10'(y);
    @(negedge clk);
  endtask

  task automatic t_reset();
    base_wr = 1'b1; base_din = 32'h0000_5000; rst = 1'b0;
    put_xy(100, 100);
    base_wr = 1'b0;
    rst = 1'b1;
    put_xy(100, 100);
    chk("R1 pix_addr in reset", pix_addr, 0);
    chk("R1 chr_addr in reset", chr_addr, 0);
    chk("R1 glyph in reset", {26'h0, glyph_row, glyph_col}, 0);
    chk("R1 rgb in reset", rgb_word(), 0);
    rst = 1'b0;
    cur_base = 32'h0;
    put_xy(2, 0);
    chk("R1 base back to reset value", pix_addr, 32'h2);
  endtask

  task automatic t_pix_addr();
    int xs[4] = '{0, 0, 638, 200};
    int ys[4] = '{0, 2, 478, 37};
    for (int i = 0; i < 4; i++) begin
      put_xy(xs[i], ys[i]);
      chk("R2 pixel address", pix_addr, exp_pix(cur_base, xs[i], ys[i]));
    end
    put_xy(639, 479);
    chk("R2 last pixel offset 0x3BE7E", pix_addr, cur_base + 32'h3BE7E);
  endtask

  task automatic t_repeat();
    logic [31:0] ref_a;
    put_xy(84, 50);
    ref_a = pix_addr;
    chk("R3 block origin", ref_a, exp_pix(cur_base, 84, 50));
    put_xy(85, 50); chk("R3 odd x same pixel", pix_addr, ref_a);
    put_xy(84, 51); chk("R3 odd y same pixel", pix_addr, ref_a);
    put_xy(85, 51); chk("R3 odd x,y same pixel", pix_addr, ref_a);
    put_xy(86, 50); chk("R3 next pixel steps by 2", pix_addr, ref_a + 2);
  endtask

  task automatic t_base_write();
    base_wr = 1'b1; base_din = 32'h0020_0000;
    put_xy(2, 2);
    chk("R4 write edge uses old base", pix_addr, cur_base + 32'h402);
    base_wr = 1'b0;
    cur_base = 32'h0020_0000;
    put_xy(2, 2);
    chk("R4 new base next edge", pix_addr, 32'h0020_0402);
    base_din = 32'h0;
    put_xy(10, 10);
    chk("R4 base unchanged without strobe", pix_addr, exp_pix(cur_base, 10, 10));
  endtask

  task automatic t_char();
    put_xy(0, 8);
    chk("R5 char row stride 0x80", chr_addr, CB + 32'h80);
    put_xy(632, 472);
    chk("R5 last cell 0x1DCF", chr_addr, CB + 32'h1DCF);
    put_xy(639, 479);
    chk("R5 inside last cell", chr_addr, CB + 32'h1DCF);
    put_xy(123, 77);
    chk("R5 char address", chr_addr, exp_chr(123, 77));
  endtask

  task automatic t_glyph();
    put_xy(123, 77);
    chk("R6 glyph col", 32'(glyph_col), 32'(123 % 8));
    chk("R6 glyph row", 32'(glyph_row), 32'(77 % 8));
    put_xy(8, 15);
    chk("R6 glyph col/row", {26'h0, glyph_row, glyph_col}, {26'h0, 3'd7, 3'd0});
  endtask

  task automatic t_color();
    logic [15:0] pats[3] = '{16'hA5C3, 16'h07E0, 16'hF81F};
    for (int i = 0; i < 3; i++) begin
      pix_data = pats[i]; font_bit = 1'b0;
      put_xy(10 + i, 4);
      put_xy(10 + i, 4);
      chk("R7 pixel colour", rgb_word(),
          {16'h0, pats[i][15:11], pats[i][10:5], pats[i][4:0]});
    end
  endtask

  task automatic t_font();
    pix_data = 16'h1234; font_bit = 1'b1;
    put_xy(300, 200);
    put_xy(300, 200);
    chk("R8 font bit gives white", rgb_word(), 32'hFFFF);
    font_bit = 1'b0;
  endtask

  task automatic t_blank();
    pix_data = 16'hFFFF; font_bit = 1'b1;
    put_xy(640, 10);
    put_xy(640, 10);
    chk("R9 x past edge black", rgb_word(), 0);
    put_xy(5, 480);
    put_xy(5, 480);
    chk("R9 y past edge black", rgb_word(), 0);
    font_bit = 1'b0; pix_data = 16'h5555;
    put_xy(639, 479);
    put_xy(639, 479);
    chk("R9 last visible pixel shown", rgb_word(), 32'h5555);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_pix_addr();
    t_repeat();
    t_base_write();
    t_char();
    t_glyph();
    t_color();
    t_font();
    t_blank();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule